// File: doc/BRIEF.md
# Saturating Wiper Position Controller

This block is the digital control section of a 100-position digitally trimmed resistor. A host drives three slow pins: an active-low select, a direction level and an active-low step strobe. While the block is selected, every high-to-low transition of the strobe moves a wiper position counter one place, up or down according to the direction level. The counter stops at both ends and never wraps. The counter is decoded onto a one-hot bus of tap-enable lines. Each line closes one switch of the resistor ladder, which lies outside this block.

The block keeps a nonvolatile copy of the position, modelled as a register plus a write timer. When select is released, the level of the strobe at that moment chooses the outcome. If the strobe is high, the position is saved and the block reports busy for a programmable number of clocks. If the strobe is low, nothing is saved and the block drops straight to standby. At every reset release, which stands in for power-up, the live position is reloaded from the saved copy. On the very first power-up the saved copy holds a mid-scale default.

The control is a four-state machine:
- `ST_RECALL` loads the saved copy after reset, then moves to `ST_STANDBY`.
- `ST_STANDBY` waits for select and moves to `ST_ACTIVE` when select is low.
- `ST_ACTIVE` steps the counter. Releasing select leaves for `ST_STORE` if the strobe is high, or for `ST_STANDBY` if it is low.
- `ST_STORE` runs the write timer, then returns to `ST_STANDBY`.

Top module: `wiper_ctl`

## Requirements
- R1: The position changes only on a falling edge of the step strobe while select is low. A rising strobe edge, or any strobe while select is high, leaves `tap_o` unchanged.
- R2: With `dir_up_i` high, each active strobe edge adds one to the position. With it low, each edge subtracts one. The direction may change while select stays low, and later steps follow the new level.
- R3: The position stays within 0 to TAPS-1 (0 to 99). An up step at 99 and a down step at 0 leave it unchanged.
- R4: `tap_o` always has exactly one bit set, and that bit's index equals the current position.
- R5: Raising select while the strobe is high writes the position to the saved copy. `busy_o` is then high for exactly STORE_CYCLES clocks, after which `standby_o` goes high.
- R6: Raising select while the strobe is low writes nothing and never raises `busy_o`. `standby_o` goes high and the live position is kept.
- R7: Strobe edges that arrive while `busy_o` is high do not move the position, even if select is low.
- R8: After reset release, the position equals the saved copy. If no store has happened since time zero, it equals NV_INIT (default 50).
- R9: `standby_o` is high while the block is deselected and no store is running. It is low while the block is selected and while `busy_o` is high.
- R10: All three pins pass through two synchroniser flops. A strobe falling edge driven between clock edges shows on `tap_o` after the third following rising clock edge, and not before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset; its release acts as power-up |
| sel_n_i | input | 1 | Active-low select pin (asynchronous) |
| dir_up_i | input | 1 | Step direction; 1 = up, 0 = down (asynchronous) |
| step_n_i | input | 1 | Step strobe; falling edge steps (asynchronous) |
| tap_o | output | TAPS | One-hot tap enable; bit n is set when the position is n |
| busy_o | output | 1 | High while a nonvolatile write is running |
| standby_o | output | 1 | High while the block is idle and deselected |

## Verification
A wrong counter value is visible on `tap_o` three clocks after the strobe edge that caused it, because the decode is purely combinational from the position register. A wrong machine state shows at once on `busy_o` or `standby_o`. A missed or spurious write stays hidden until the next reset release, when the reloaded position exposes it. For that reason the bench follows every store or no-store exit with a reset and compares the recalled tap.

// File: rtl/wiper_pkg.sv
package wiper_pkg;

    typedef enum logic [1:0] {
        ST_RECALL  = 2'd0,
        ST_STANDBY = 2'd1,
        ST_ACTIVE  = 2'd2,
        ST_STORE   = 2'd3
    } wstate_e;

endpackage

// File: rtl/wiper_sync.sv
module wiper_sync #(
    parameter int          W       = 3,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    // Two-flop synchroniser, one lane per pin.
    for (genvar g = 0; g < W; g++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q[g] <= RST_VAL[g];
                sync_q[g] <= RST_VAL[g];
            end else begin
                meta_q[g] <= d_i[g];
                sync_q[g] <= meta_q[g];
            end
        end
    end

    assign q_o = sync_q;

endmodule

// File: rtl/wiper_nvstore.sv
module wiper_nvstore #(
    parameter int PW           = 7,
    parameter int NV_INIT      = 50,
    parameter int STORE_CYCLES = 500000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [PW-1:0] wr_data_i,
    output logic [PW-1:0] nv_data_o,
    output logic          done_o
);

    localparam int          CW   = $clog2(STORE_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(STORE_CYCLES - 1);

    // Saved copy: not cleared by reset, so it survives a power cycle.
    logic [PW-1:0] nv_q = PW'(NV_INIT);
    logic [CW-1:0] cnt_q;
    logic          run_q;

    always_ff @(posedge clk) begin
        if (start_i) begin
            nv_q <= wr_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (start_i) begin
            run_q <= 1'b1;
            cnt_q <= '0;
        end else if (run_q) begin
            if (cnt_q == LAST) begin
                run_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign nv_data_o = nv_q;
    assign done_o    = run_q && (cnt_q == LAST);

    // R5: a write request lands in the saved copy on the next edge.
    a_r5_write_captured: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (nv_data_o == $past(wr_data_i)));

    // R5: the timer never completes on the cycle it is started.
    a_r5_no_instant_done: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (run_q && cnt_q == '0));

endmodule

// File: rtl/wiper_decode.sv
module wiper_decode #(
    parameter int TAPS = 100,
    parameter int PW   = 7
) (
    input  logic [PW-1:0]   pos_i,
    output logic [TAPS-1:0] tap_o
);

    for (genvar t = 0; t < TAPS; t++) begin : g_tap
        assign tap_o[t] = (pos_i == PW'(t));
    end

endmodule

// File: rtl/wiper_ctl.sv
module wiper_ctl
    import wiper_pkg::*;
#(
    parameter int TAPS         = 100,
    parameter int NV_INIT      = TAPS / 2,
    parameter int STORE_CYCLES = 500000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sel_n_i,
    input  logic            dir_up_i,
    input  logic            step_n_i,
    output logic [TAPS-1:0] tap_o,
    output logic            busy_o,
    output logic            standby_o
);

    localparam int          PW  = $clog2(TAPS);
    localparam logic [PW-1:0] TOP = PW'(TAPS - 1);

    wstate_e       st_q, st_nxt;
    logic [PW-1:0] pos_q;
    logic [2:0]    pins_s;
    logic          sel_s, up_s, stb_s, stb_d;
    logic          stb_fall;
    logic          store_go, load_go, step_go, store_done;
    logic [PW-1:0] nv_data;

    // Pins: {select, direction, strobe}; idle levels are select high, strobe high.
    wiper_sync #(.W(3), .RST_VAL(3'b101)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({sel_n_i, dir_up_i, step_n_i}),
        .q_o   (pins_s)
    );

    assign sel_s = pins_s[2];
    assign up_s  = pins_s[1];
    assign stb_s = pins_s[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stb_d <= 1'b1;
        end else begin
            stb_d <= stb_s;
        end
    end

    assign stb_fall = stb_d && !stb_s;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_RECALL;
        end else begin
            st_q <= st_nxt;
        end
    end

    // Next-state logic.
    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            ST_RECALL:  st_nxt = ST_STANDBY;
            ST_STANDBY: if (!sel_s) st_nxt = ST_ACTIVE;
            ST_ACTIVE:  if (sel_s)  st_nxt = stb_s ? ST_STORE : ST_STANDBY;
            ST_STORE:   if (store_done) st_nxt = ST_STANDBY;
            default:    st_nxt = ST_RECALL;
        endcase
    end

    // Outputs and per-state strobes.
    always_comb begin
        busy_o    = (st_q == ST_STORE);
        standby_o = (st_q == ST_STANDBY);
        load_go   = (st_q == ST_RECALL);
        store_go  = (st_q == ST_ACTIVE) && sel_s && stb_s;
        step_go   = (st_q == ST_ACTIVE) && !sel_s && stb_fall;
    end

    // Saturating position counter.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else if (load_go) begin
            pos_q <= nv_data;
        end else if (step_go) begin
            if (up_s && pos_q != TOP) begin
                pos_q <= pos_q + 1'b1;
            end else if (!up_s && pos_q != '0) begin
                pos_q <= pos_q - 1'b1;
            end
        end
    end

    wiper_nvstore #(
        .PW           (PW),
        .NV_INIT      (NV_INIT),
        .STORE_CYCLES (STORE_CYCLES)
    ) u_nv (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (store_go),
        .wr_data_i (pos_q),
        .nv_data_o (nv_data),
        .done_o    (store_done)
    );

    wiper_decode #(.TAPS(TAPS), .PW(PW)) u_dec (
        .pos_i (pos_q),
        .tap_o (tap_o)
    );

    // R3: the counter never leaves the tap range.
    a_r3_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        pos_q <= TOP);

    // R3: no wrap at either end.
    a_r3_hold_top: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_RECALL && pos_q == TOP && up_s) |=> (pos_q == TOP));
    a_r3_hold_bottom: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_RECALL && pos_q == '0 && !up_s) |=> (pos_q == '0));

    // R1: no strobe edge while selected means no movement.
    a_r1_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_RECALL && !(st_q == ST_ACTIVE && stb_fall)) |=> $stable(pos_q));

    // R4: decoded bus is one-hot at the counter's index.
    a_r4_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(tap_o) == 1) && tap_o[pos_q]);

    // R6: release with strobe low never starts a write.
    a_r6_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_ACTIVE && sel_s && !stb_s) |=> (!busy_o && standby_o));

    // R7: position frozen while a write runs.
    a_r7_busy_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> $stable(pos_q));

endmodule

// File: tb/wiper_ctl_tb.sv
module wiper_ctl_tb;

    localparam int TAPS = 100;
    localparam int SC   = 24;
    localparam int INIT = 50;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            sel_n, dir_up, step_n;
    logic [TAPS-1:0] tap;
    logic            busy, standby;

    int total = 0;
    int bad   = 0;
    int exp_pos;
    bit finished = 0;

    always #10 clk = ~clk;

    wiper_ctl #(.TAPS(TAPS), .NV_INIT(INIT), .STORE_CYCLES(SC)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_n_i   (sel_n),
        .dir_up_i  (dir_up),
        .step_n_i  (step_n),
        .tap_o     (tap),
        .busy_o    (busy),
        .standby_o (standby)
    );

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_pos(input int e, input string req);
        logic [TAPS-1:0] ev;
        ev    = '0;
        ev[e] = 1'b1;
        total++;
        if (tap !== ev) begin
            bad++;
            $display("FAIL %s tap: actual=%h expected=%h (pos %0d)", req, tap, ev, e);
        end
    endtask

    task automatic check_bit(input logic act, input logic e, input string req, input string what);
        total++;
        if (act !== e) begin
            bad++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, e);
        end
    endtask

    task automatic check_int(input int act, input int e, input string req, input string what);
        total++;
        if (act != e) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, e);
        end
    endtask

    function automatic int step_of(input int p, input bit up);
        if (up)  return (p == TAPS - 1) ? p : p + 1;
        else     return (p == 0) ? p : p - 1;
    endfunction

    task automatic pulse();
        step_n = 1'b0;
        waitn(4);
        step_n = 1'b1;
        waitn(4);
    endtask

    task automatic power_cycle();
        rst_n = 1'b0;
        waitn(3);
        rst_n = 1'b1;
        waitn(4);
    endtask

    initial begin : stim
        int busy_cnt;
        bit pat [7] = '{1, 1, 1, 0, 1, 0, 0};
        rst_n  = 1'b0;
        sel_n  = 1'b1;
        dir_up = 1'b0;
        step_n = 1'b1;
        waitn(5);
        rst_n = 1'b1;
        waitn(4);

        // R8 first power-up default; R9 idle standby
        exp_pos = INIT;
        check_pos(exp_pos, "R8");
        check_bit(standby, 1'b1, "R9", "standby after reset");
        check_bit(busy, 1'b0, "R9", "busy after reset");

        sel_n = 1'b0;
        waitn(5);
        check_bit(standby, 1'b0, "R9", "standby while selected");

        // R10 latency: changes after third edge, not second
        dir_up = 1'b1;
        waitn(4);
        step_n = 1'b0;
        waitn(2);
        check_pos(exp_pos, "R10");
        waitn(1);
        exp_pos = step_of(exp_pos, 1);
        check_pos(exp_pos, "R10");
        step_n = 1'b1;
        waitn(4);
        check_pos(exp_pos, "R1");   // rising edge: no move

        // R2/R3/R4 up sweep to the top and beyond
        for (int i = 0; i < 55; i++) begin
            pulse();
            exp_pos = step_of(exp_pos, 1);
            check_pos(exp_pos, "R3");
        end
        // R2 direction change while selected, down sweep past zero
        dir_up = 1'b0;
        waitn(4);
        for (int i = 0; i < 110; i++) begin
            pulse();
            exp_pos = step_of(exp_pos, 0);
            check_pos(exp_pos, "R2");
        end
        // R2 mixed directions
        for (int i = 0; i < 7; i++) begin
            dir_up = pat[i];
            waitn(4);
            pulse();
            exp_pos = step_of(exp_pos, pat[i]);
            check_pos(exp_pos, "R2");
        end

        // R6 release with strobe low: the final fall steps, then no write
        step_n = 1'b0;
        waitn(4);
        exp_pos = step_of(exp_pos, dir_up);
        sel_n = 1'b1;
        busy_cnt = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (busy) busy_cnt++;
        end
        check_int(busy_cnt, 0, "R6", "busy cycles");
        check_bit(standby, 1'b1, "R6", "standby");
        check_pos(exp_pos, "R6");
        step_n = 1'b1;
        waitn(4);

        // R1 strobes while deselected are ignored
        for (int i = 0; i < 3; i++) pulse();
        check_pos(exp_pos, "R1");

        // R8 nothing saved: recall gives the default
        power_cycle();
        exp_pos = INIT;
        check_pos(exp_pos, "R8");

        // R5 store with exact busy length
        sel_n  = 1'b0;
        dir_up = 1'b1;
        waitn(5);
        for (int i = 0; i < 7; i++) begin
            pulse();
            exp_pos = step_of(exp_pos, 1);
        end
        check_pos(exp_pos, "R2");
        sel_n = 1'b1;
        busy_cnt = 0;
        for (int i = 0; i < SC + 20; i++) begin
            @(negedge clk);
            if (busy) begin
                busy_cnt++;
                if (standby) begin
                    total++; bad++;
                    $display("FAIL R9 standby during busy: actual=1 expected=0");
                end
            end
        end
        check_int(busy_cnt, SC, "R5", "busy cycles");
        check_bit(standby, 1'b1, "R5", "standby after store");
        power_cycle();
        check_pos(exp_pos, "R8");   // 57 recalled

        // R7 strobes during busy ignored
        sel_n  = 1'b0;
        dir_up = 1'b0;
        waitn(5);
        for (int i = 0; i < 3; i++) begin
            pulse();
            exp_pos = step_of(exp_pos, 0);
        end
        sel_n = 1'b1;
        waitn(3);
        check_bit(busy, 1'b1, "R5", "busy after release");
        sel_n = 1'b0;
        pulse();
        pulse();
        check_bit(busy, 1'b1, "R7", "still busy");
        waitn(SC + 6);
        check_bit(busy, 1'b0, "R7", "busy ended");
        check_pos(exp_pos, "R7");
        check_bit(standby, 1'b0, "R9", "reselected after store");
        sel_n = 1'b1;
        waitn(SC + 10);
        power_cycle();
        check_pos(exp_pos, "R8");   // 54 recalled

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule